// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers a set of nonmaskable trap requests and a larger set of maskable peripheral interrupt requests. It reduces them to one request line toward the CPU, together with the number and program-memory address of the vector entry to fetch. Each request pulse is latched as pending. Arbitration runs combinationally over the pending set and the result is registered, so the request, vector number and vector address change on the same clock edge that samples a new request.

Arbitration has two levels. Traps always rank above maskable interrupts. Maskable sources carry an enable and a 3-bit user priority, and compete on that priority first. Ties at any level go to the lower vector number. A control bit written through a small register port moves every vector lookup to an alternate table that sits right after the primary one. The bit takes effect at the next acknowledge, so a vector already on offer is never rewritten by a table switch.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset, `cpu_irq` is 0, `vec_num` and `vec_addr` are 0, and the primary table is selected.
- R2: A high sample on a request input sets that source pending. The edge that samples it also raises `cpu_irq` if the source is eligible. `cpu_irq` then stays high until an acknowledge.
- R3: Trap requests ignore enables and `cpu_prio` and outrank every maskable source. Among traps, the lowest index wins.
- R4: A maskable source is offered only when its enable is 1, its priority is nonzero and its priority is strictly greater than `cpu_prio`.
- R5: Among eligible maskable sources, the higher priority wins. Equal priorities go to the lower vector number.
- R6: Trap t has vector number t and maskable source j has vector number 8+j. The vector address is base + 2 * number, with a primary base of 0x000004.
- R7: Writing `ctl_wdata[15]`=1 selects the alternate table, whose base is 0x000104. The selection is adopted only on an acknowledge edge, so the vector currently offered keeps its table. Other write-data bits are ignored.
- R8: When `cpu_ack` is high while `cpu_irq` is high, the offered source's pending flag is cleared and the next winner appears after that edge. `cpu_ack` while `cpu_irq` is low changes nothing.
- R9: A pending source that is masked by its enable, its priority or `cpu_prio` stays pending. It is offered once the mask is lifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | N_TRAPS | Trap request inputs, index 0 highest |
| irq_req | input | N_IRQ | Maskable interrupt request inputs |
| irq_en | input | N_IRQ | Per-source enables |
| irq_prio | input | 3*N_IRQ | Per-source priority, source j in bits [3j+2:3j] |
| cpu_prio | input | 3 | Current CPU priority |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 16 | Control register write data, bit 15 selects the alternate table |
| cpu_ack | input | 1 | CPU acknowledge of the offered vector |
| cpu_irq | output | 1 | Request toward the CPU |
| vec_num | output | 7 | Offered vector number |
| vec_addr | output | 24 | Program address of the offered vector entry |

## Verification
A corrupted pending flag shows at the ports within one edge. A request is either offered when it should not be or missing when it should be, and the error also shows after the acknowledge that follows, as a wrong next winner or a wrong drop of `cpu_irq`. A wrong priority compare or a wrong tie order shows directly as a wrong `vec_num` in the first cycle that two sources compete. A wrong table select shows as a `vec_addr` off by 0x100. Because the select is latched, this error may surface only at the first vector issued after an acknowledge, so the bench switches tables with a request outstanding and checks the addresses on both sides of the acknowledge.

// File: rtl/prio_vec_intc_pkg.sv
package prio_vec_intc_pkg;
  localparam int VEC_W      = 7;
  localparam int ADDR_W     = 24;
  localparam int TRAP_SLOTS = 8;
  localparam int UPRIO_W    = 3;
  localparam int EPRIO_W    = UPRIO_W + 1;
  localparam int CTL_W      = 16;
  localparam int CTL_ALT_BIT = 15;
  localparam logic [ADDR_W-1:0] PRI_BASE   = 24'h000004;
  localparam logic [ADDR_W-1:0] ALT_OFFSET = 24'h000100;
  localparam logic [EPRIO_W-1:0] TRAP_RANK = EPRIO_W'(1 << UPRIO_W);

  typedef struct packed {
    logic               valid;
    logic [VEC_W-1:0]   num;
    logic [EPRIO_W-1:0] rank;
  } win_t;

  // vector number of flat source index i (traps first)
  function automatic logic [VEC_W-1:0] src_vec(input int i, input int ntraps);
    if (i < ntraps) return VEC_W'(i);
    return VEC_W'(TRAP_SLOTS + i - ntraps);
  endfunction

  // table entry address: base plus two units per vector
  function automatic logic [ADDR_W-1:0] vec_addr(input logic alt, input logic [VEC_W-1:0] num);
    logic [ADDR_W-1:0] base;
    base = alt ? (PRI_BASE + ALT_OFFSET) : PRI_BASE;
    return base + {{(ADDR_W-VEC_W-1){1'b0}}, num, 1'b0};
  endfunction

  // effective rank: traps above every user level
  function automatic logic [EPRIO_W-1:0] src_rank(input logic is_trap, input logic [UPRIO_W-1:0] up);
    return is_trap ? TRAP_RANK : {1'b0, up};
  endfunction
endpackage

// File: rtl/prio_vec_intc_pending.sv
module prio_vec_intc_pending #(
  parameter int NS = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] set_i,
  input  logic [NS-1:0] clr_i,
  output logic [NS-1:0] pend_q,
  output logic [NS-1:0] pend_n
);
  for (genvar i = 0; i < NS; i++) begin : g_bit
    assign pend_n[i] = (pend_q[i] & ~clr_i[i]) | set_i[i];

    always_ff @(posedge clk) begin
      if (!rst_n) pend_q[i] <= 1'b0;
      else        pend_q[i] <= pend_n[i];
    end

    // R8
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !set_i[i]) |=> !pend_q[i]);

    // R2
    set_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> pend_q[i]);
  end
endmodule

// File: rtl/prio_vec_intc_arbiter.sv
module prio_vec_intc_arbiter
  import prio_vec_intc_pkg::*;
#(
  parameter int N_TRAPS = 4,
  parameter int N_IRQ   = 16,
  localparam int NS     = N_TRAPS + N_IRQ
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NS-1:0]            pend_i,
  input  logic [N_IRQ-1:0]         irq_en,
  input  logic [UPRIO_W*N_IRQ-1:0] irq_prio,
  input  logic [UPRIO_W-1:0]       cpu_prio,
  output win_t                     win_o
);
  logic [NS-1:0]      elig;
  logic [EPRIO_W-1:0] rank [NS];
  logic [VEC_W-1:0]   vnum [NS];

  for (genvar i = 0; i < NS; i++) begin : g_src
    assign vnum[i] = src_vec(i, N_TRAPS);
    if (i < N_TRAPS) begin : g_trap
      assign rank[i] = src_rank(1'b1, '0);
      assign elig[i] = pend_i[i];
    end else begin : g_irq
      logic [UPRIO_W-1:0] up;
      assign up      = irq_prio[UPRIO_W*(i-N_TRAPS) +: UPRIO_W];
      assign rank[i] = src_rank(1'b0, up);
      assign elig[i] = pend_i[i] & irq_en[i-N_TRAPS] & (up != '0) & (up > cpu_prio);
    end
  end

  // strict compare keeps the lowest index among equal ranks
  always_comb begin
    win_o = '0;
    for (int i = 0; i < NS; i++) begin
      if (elig[i] && (!win_o.valid || rank[i] > win_o.rank)) begin
        win_o.valid = 1'b1;
        win_o.num   = vnum[i];
        win_o.rank  = rank[i];
      end
    end
  end

  // R3
  trap_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend_i[N_TRAPS-1:0]) |-> (win_o.valid && win_o.rank == TRAP_RANK && win_o.num < VEC_W'(N_TRAPS)));

  // R4
  above_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_o.valid && win_o.rank != TRAP_RANK) |-> (win_o.rank > {1'b0, cpu_prio}));
endmodule

// File: rtl/prio_vec_intc_vecreg.sv
module prio_vec_intc_vecreg
  import prio_vec_intc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  win_t              win_i,
  input  logic              ack_fire,
  input  logic              ctl_alt,
  output logic              req_q,
  output logic [VEC_W-1:0]  num_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              alt_sel_q
);
  logic alt_eff;
  assign alt_eff = ack_fire ? ctl_alt : alt_sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q     <= 1'b0;
      num_q     <= '0;
      addr_q    <= '0;
      alt_sel_q <= 1'b0;
    end else begin
      req_q     <= win_i.valid;
      alt_sel_q <= alt_eff;
      if (win_i.valid) begin
        num_q  <= win_i.num;
        addr_q <= vec_addr(alt_eff, win_i.num);
      end
    end
  end

  // R7
  alt_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_fire |=> $stable(alt_sel_q));

  // R2
  req_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_i.valid |=> req_q);
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
  import prio_vec_intc_pkg::*;
#(
  parameter int N_TRAPS = 4,
  parameter int N_IRQ   = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_TRAPS-1:0]       trap_req,
  input  logic [N_IRQ-1:0]         irq_req,
  input  logic [N_IRQ-1:0]         irq_en,
  input  logic [3*N_IRQ-1:0]       irq_prio,
  input  logic [2:0]               cpu_prio,
  input  logic                     ctl_wr,
  input  logic [15:0]              ctl_wdata,
  input  logic                     cpu_ack,
  output logic                     cpu_irq,
  output logic [6:0]               vec_num,
  output logic [23:0]              vec_addr
);
  localparam int NS = N_TRAPS + N_IRQ;

  logic          ctl_alt_q;
  logic          ack_fire;
  logic [NS-1:0] set_m, clr_m, pend_q, pend_n;
  win_t          win;
  logic          alt_sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      ctl_alt_q <= 1'b0;
    else if (ctl_wr) ctl_alt_q <= ctl_wdata[CTL_ALT_BIT];
  end

  assign ack_fire = cpu_ack & cpu_irq;
  assign set_m    = {irq_req, trap_req};

  for (genvar i = 0; i < NS; i++) begin : g_clr
    assign clr_m[i] = ack_fire && (vec_num == src_vec(i, N_TRAPS));
  end

  prio_vec_intc_pending #(.NS(NS)) pend_i (
    .clk(clk), .rst_n(rst_n), .set_i(set_m), .clr_i(clr_m),
    .pend_q(pend_q), .pend_n(pend_n)
  );

  prio_vec_intc_arbiter #(.N_TRAPS(N_TRAPS), .N_IRQ(N_IRQ)) arb_i (
    .clk(clk), .rst_n(rst_n), .pend_i(pend_n), .irq_en(irq_en),
    .irq_prio(irq_prio), .cpu_prio(cpu_prio), .win_o(win)
  );

  prio_vec_intc_vecreg vreg_i (
    .clk(clk), .rst_n(rst_n), .win_i(win), .ack_fire(ack_fire),
    .ctl_alt(ctl_alt_q), .req_q(cpu_irq), .num_q(vec_num),
    .addr_q(vec_addr), .alt_sel_q(alt_sel_q)
  );

  // R8
  ack_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_m));

  // R8
  ack_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |-> ($countones(clr_m & pend_q) == 1));
endmodule

// File: tb/prio_vec_intc_tb_top.sv
module prio_vec_intc_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 4;
  localparam int NI = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic [NT-1:0] trap_req;
  logic [NI-1:0] irq_req, irq_en;
  logic [3*NI-1:0] irq_prio;
  logic [2:0] cpu_prio;
  logic ctl_wr;
  logic [15:0] ctl_wdata;
  logic cpu_ack;
  logic cpu_irq;
  logic [6:0] vec_num;
  logic [23:0] vec_addr;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_vec_intc #(.N_TRAPS(NT), .N_IRQ(NI)) dut_i (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .irq_req(irq_req),
    .irq_en(irq_en), .irq_prio(irq_prio), .cpu_prio(cpu_prio),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .cpu_ack(cpu_ack),
    .cpu_irq(cpu_irq), .vec_num(vec_num), .vec_addr(vec_addr)
  );

  function automatic int exp_addr(input int alt, input int num);
    return 4 + 256 * alt + num * 2;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulse_irq(input int j);
    irq_req[j] = 1'b1; step(); irq_req = '0;
  endtask

  task automatic pulse_trap(input int t);
    trap_req[t] = 1'b1; step(); trap_req = '0;
  endtask

  task automatic do_ack();
    cpu_ack = 1'b1; step(); cpu_ack = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; trap_req = '0; irq_req = '0; irq_en = '1; irq_prio = '0;
    cpu_prio = '0; ctl_wr = 1'b0; ctl_wdata = '0; cpu_ack = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    check("R1 irq", int'(cpu_irq), 0);
    check("R1 num", int'(vec_num), 0);
    check("R1 addr", int'(vec_addr), 0);

    // single source sweep: priority versus cpu level, addresses
    for (int j = 0; j < NI; j++) begin
      for (int p = 0; p < 8; p++) begin
        for (int cp = 0; cp < 8; cp++) begin
          irq_prio = '0;
          irq_prio[3*j +: 3] = 3'(p);
          cpu_prio = 3'(cp);
          pulse_irq(j);
          check("R4 gate", int'(cpu_irq), (p != 0 && p > cp) ? 1 : 0);
          if (p != 0 && p > cp) begin
            check("R6 num", int'(vec_num), 8 + j);
            check("R6 addr", int'(vec_addr), exp_addr(0, 8 + j));
          end
          if (p == 0) irq_prio[3*j +: 3] = 3'd1;
          cpu_prio = '0;
          step();
          check("R9 held", int'(cpu_irq), 1);
          do_ack();
          check("R8 drop", int'(cpu_irq), 0);
        end
      end
    end

    // enable masking
    irq_prio = '1; cpu_prio = '0;
    for (int j = 0; j < NI; j++) begin
      irq_en[j] = 1'b0;
      pulse_irq(j);
      check("R4 disabled", int'(cpu_irq), 0);
      irq_en[j] = 1'b1;
      step();
      check("R9 enabled", int'(vec_num), 8 + j);
      do_ack();
    end

    // pairs: priority then natural order
    for (int a = 0; a < NI; a++) begin
      for (int b = a + 1; b < NI; b++) begin
        for (int ia = 0; ia < 3; ia++) begin
          for (int ib = 0; ib < 3; ib++) begin
            int pa, pb, w, l;
            pa = 1 + 3 * ia; pb = 1 + 3 * ib;
            irq_prio = '0;
            irq_prio[3*a +: 3] = 3'(pa);
            irq_prio[3*b +: 3] = 3'(pb);
            w = (pb > pa) ? b : a;
            l = (w == a) ? b : a;
            irq_req[a] = 1'b1; irq_req[b] = 1'b1; step(); irq_req = '0;
            check("R5 first", int'(vec_num), 8 + w);
            do_ack();
            check("R5 second", int'(vec_num), 8 + l);
            check("R8 next", int'(cpu_irq), 1);
            do_ack();
            check("R8 empty", int'(cpu_irq), 0);
          end
        end
      end
    end

    // traps: nonmaskable, outrank interrupts
    irq_en = '0; cpu_prio = 3'd7; irq_prio = '1;
    for (int t = 0; t < NT; t++) begin
      pulse_trap(t);
      check("R3 trap num", int'(vec_num), t);
      check("R6 trap addr", int'(vec_addr), exp_addr(0, t));
      do_ack();
      check("R3 trap done", int'(cpu_irq), 0);
    end
    irq_en = '1; cpu_prio = 3'd6; irq_prio = '0; irq_prio[3*3 +: 3] = 3'd7;
    pulse_irq(3);
    check("R3 irq pre", int'(vec_num), 11);
    trap_req[2] = 1'b1; trap_req[1] = 1'b1; step(); trap_req = '0;
    check("R3 low trap", int'(vec_num), 1);
    do_ack();
    check("R3 next trap", int'(vec_num), 2);
    do_ack();
    check("R3 back to irq", int'(vec_num), 11);
    do_ack();
    check("R3 idle", int'(cpu_irq), 0);

    // ack while idle is ignored
    cpu_prio = 3'd7; irq_prio = '0; irq_prio[3*2 +: 3] = 3'd3;
    pulse_irq(2);
    check("R9 masked", int'(cpu_irq), 0);
    do_ack();
    cpu_prio = '0;
    step();
    check("R8 idle ack", int'(vec_num), 10);
    check("R8 idle ack irq", int'(cpu_irq), 1);
    do_ack();

    // alternate table, adopted at acknowledge
    irq_prio = '0; irq_prio[3*5 +: 3] = 3'd3;
    pulse_irq(5);
    check("R6 primary", int'(vec_addr), exp_addr(0, 13));
    ctl_wr = 1'b1; ctl_wdata = 16'h8000; step(); ctl_wr = 1'b0;
    step();
    check("R7 unchanged", int'(vec_addr), exp_addr(0, 13));
    do_ack();
    pulse_irq(5);
    check("R7 alt irq", int'(vec_addr), exp_addr(1, 13));
    do_ack();
    pulse_trap(0);
    check("R7 alt trap", int'(vec_addr), exp_addr(1, 0));
    ctl_wr = 1'b1; ctl_wdata = 16'h7FFF; step(); ctl_wr = 1'b0;
    check("R7 still alt", int'(vec_addr), exp_addr(1, 0));
    do_ack();
    pulse_irq(5);
    check("R7 back primary", int'(vec_addr), exp_addr(0, 13));
    do_ack();
    check("R8 final", int'(cpu_irq), 0);

    finish_run();
  end
endmodule